// File: doc/BRIEF.md
# DRAM Access Timing Engine

This block paces read and write bursts to a single-rank double-data-rate DRAM device. A requester presents one command at a time on a valid/ready handshake. The command carries a bank, a row, a column and a read/write flag. The engine decides when the command may issue. It then marks the clock cycles in which read data is returned (`rd_valid`) or write data is taken (`wr_strobe`). It models timing only and stores no data.

Each bank has an open-row register with a valid bit. The delay before the first data beat depends on three things: whether the bank already holds the addressed row, whether the bank is closed, or whether a different row must be left first. A read that comes straight after a write also pays a turnaround. A free-running timer raises a refresh request at a fixed interval. When it is raised during a burst, the refresh waits until that burst is finished. The refresh then blocks all traffic for a fixed time and closes every bank.

Every delay is a parameter given in nanoseconds and rounded up to whole clock cycles. With the defaults (5 ns clock, burst of 4 transfers) the delays in cycles are: refresh interval 1520, refresh blackout 24, row hop 11, activate-to-access 3, read latency 2, write latency 2, write-to-read turnaround 2. A burst takes 2 clock cycles.

Top module: `dram_timing_engine`

## Requirements
- R1: After reset, `cmd_ready` is 1, `rd_valid` and `wr_strobe` are 0, and every bank is closed.
- R2: Cycle t is the cycle whose closing clock edge sees both `cmd_valid` and `cmd_ready` high. For a read to the row already open in its bank, `rd_valid` first rises in cycle t+1+2 (read latency). The column does not change the timing. The column must be burst aligned: its 2 low bits are 0.
- R3: For a write to the row already open in its bank, `wr_strobe` first rises in cycle t+1+2 (write latency).
- R4: An access to a closed bank adds the activate delay of 3 cycles before the first beat. The row then becomes open in that bank.
- R5: An access to a bank whose open row differs from the addressed row adds the row-hop delay of 11 cycles plus the activate delay of 3 cycles. The new row then becomes the open row.
- R6: A read accepted directly after a write (the write being the previous accepted command) adds a turnaround of 2 cycles.
- R7: Each burst asserts exactly one strobe for 2 consecutive cycles: `rd_valid` for a read (`cmd_write`=0) or `wr_strobe` for a write (`cmd_write`=1). The other strobe stays 0. The two strobes are never high together.
- R8: Only one command is in flight. `cmd_ready` is 0 from the cycle after acceptance through the last data beat. It is 1 in the cycle after the last beat unless a refresh is pending.
- R9: A refresh request is raised in cycle 1520 after reset release and every 1520 cycles after that. If the engine is idle, `cmd_ready` is 0 in the request cycle and in the following 24 blackout cycles, and no strobe is high in them.
- R10: A refresh request raised while a command is in flight is held. It starts its blackout in the second cycle after that burst's last beat. `cmd_ready` stays 0 from the last beat through the 24 blackout cycles.
- R11: A refresh closes every bank, so the next access to any bank pays the activate delay of R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is presented |
| cmd_ready | output | 1 | Engine can accept a command this cycle |
| cmd_write | input | 1 | 1 = write burst, 0 = read burst |
| cmd_bank | input | 2 | Bank index |
| cmd_row | input | 13 | Row index |
| cmd_col | input | 10 | Column index, burst aligned |
| wr_strobe | output | 1 | Write data is taken this cycle |
| rd_valid | output | 1 | Read data is returned this cycle |

## Verification
A wrong open-row register or valid bit does not stay hidden. The next access to that bank starts its data beats 3 or 14 cycles earlier or later than it should, so the error shows on the first command to that bank. A wrong refresh timer or a lost pending flag shows within one refresh interval of 1520 cycles: either `cmd_ready` stays high in a cycle that should be blacked out, or an access after the refresh skips its activate delay. A stale turnaround flag moves the first `rd_valid` of the next read by 2 cycles.

// File: rtl/dte_pkg.sv
package dte_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_PREP = 2'd1,
      ST_DATA = 2'd2,
      ST_REF  = 2'd3
   } dte_state_e;

   function automatic int ns_to_cyc(input int t_ns, input int clk_ns);
      return (t_ns + clk_ns - 1) / clk_ns;
   endfunction
endpackage

// File: rtl/dte_refresh.sv
module dte_refresh #(
   parameter int INTERVAL = 1520
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ack,
   output logic pending
);
   localparam int CW = $clog2(INTERVAL);

   if (INTERVAL < 2) begin : g_bad_interval
      $error("dte_refresh: INTERVAL must be at least 2");
   end

   logic [CW-1:0] tick_q;
   logic          due;

   assign due = (tick_q == CW'(INTERVAL - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tick_q  <= '0;
         pending <= 1'b0;
      end else begin
         tick_q  <= due ? '0 : tick_q + 1'b1;
         if (due)
            pending <= 1'b1;
         else if (ack)
            pending <= 1'b0;
      end
   end

   // R10
   pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pending && !ack |=> pending);
endmodule

// File: rtl/dte_bank_table.sv
module dte_bank_table #(
   parameter int BANK_W = 2,
   parameter int ROW_W  = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BANK_W-1:0] q_bank,
   input  logic [ROW_W-1:0]  q_row,
   output logic              hit,
   output logic              is_open,
   input  logic              upd,
   input  logic              close_all
);
   localparam int NB = 1 << BANK_W;

   logic [NB-1:0] hit_v;
   logic [NB-1:0] open_v;

   for (genvar b = 0; b < NB; b++) begin : g_bank
      logic [ROW_W-1:0] row_q;
      logic             vld_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            row_q <= '0;
            vld_q <= 1'b0;
         end else if (close_all) begin
            vld_q <= 1'b0;
         end else if (upd && q_bank == BANK_W'(b)) begin
            row_q <= q_row;
            vld_q <= 1'b1;
         end
      end
      assign open_v[b] = vld_q;
      assign hit_v[b]  = vld_q && (row_q == q_row);
   end

   assign hit     = hit_v[q_bank];
   assign is_open = open_v[q_bank];

   // R11
   close_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      close_all |=> open_v == '0);
   // R4
   row_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd && !close_all |=> open_v[$past(q_bank)]);
endmodule

// File: rtl/dte_sched.sv
module dte_sched
   import dte_pkg::*;
#(
   parameter int HOP_C   = 11,
   parameter int RCD_C   = 3,
   parameter int CAS_C   = 2,
   parameter int DQSS_C  = 2,
   parameter int WTR_C   = 2,
   parameter int REF_C   = 24,
   parameter int BURST_C = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_valid,
   input  logic cmd_write,
   input  logic row_hit,
   input  logic bank_open,
   input  logic ref_pend,
   output logic cmd_ready,
   output logic accept,
   output logic ref_ack,
   output logic rd_valid,
   output logic wr_strobe
);
   localparam int LAT_MAX = (CAS_C > DQSS_C) ? CAS_C : DQSS_C;
   localparam int DLY_MAX = HOP_C + RCD_C + WTR_C + LAT_MAX;
   localparam int TOP_A   = (DLY_MAX > REF_C) ? DLY_MAX : REF_C;
   localparam int TOP     = (TOP_A > BURST_C) ? TOP_A : BURST_C;
   localparam int CW      = $clog2(TOP + 1);

   if (CAS_C < 1 || DQSS_C < 1 || REF_C < 1 || BURST_C < 1) begin : g_bad_lat
      $error("dte_sched: latencies, refresh and burst must be at least one cycle");
   end

   dte_state_e    state_q;
   logic [CW-1:0] cnt_q;
   logic          is_wr_q;
   logic          last_wr_q;
   logic [CW-1:0] lead;

   assign cmd_ready = (state_q == ST_IDLE) && !ref_pend;
   assign accept    = cmd_valid && cmd_ready;
   assign ref_ack   = (state_q == ST_IDLE) && ref_pend;
   assign rd_valid  = (state_q == ST_DATA) && !is_wr_q;
   assign wr_strobe = (state_q == ST_DATA) && is_wr_q;

   always_comb begin
      lead = cmd_write ? CW'(DQSS_C) : CW'(CAS_C);
      if (!row_hit)
         lead = lead + (bank_open ? CW'(HOP_C + RCD_C) : CW'(RCD_C));
      if (!cmd_write && last_wr_q)
         lead = lead + CW'(WTR_C);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         cnt_q     <= '0;
         is_wr_q   <= 1'b0;
         last_wr_q <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (ref_ack) begin
                  state_q <= ST_REF;
                  cnt_q   <= CW'(REF_C);
               end else if (accept) begin
                  state_q   <= ST_PREP;
                  cnt_q     <= lead;
                  is_wr_q   <= cmd_write;
                  last_wr_q <= cmd_write;
               end
            end
            ST_PREP: begin
               if (cnt_q == CW'(1)) begin
                  state_q <= ST_DATA;
                  cnt_q   <= CW'(BURST_C);
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            ST_DATA, ST_REF: begin
               if (cnt_q == CW'(1))
                  state_q <= ST_IDLE;
               else
                  cnt_q <= cnt_q - 1'b1;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R7
   one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_valid && wr_strobe));
   // R8
   busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !cmd_ready);
   // R9
   ref_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ref_ack |=> !rd_valid && !wr_strobe && !cmd_ready);
endmodule

// File: rtl/dram_timing_engine.sv
module dram_timing_engine
   import dte_pkg::*;
#(
   parameter int BANK_W     = 2,
   parameter int ROW_W      = 13,
   parameter int COL_W      = 10,
   parameter int ADDR_W     = 25,
   parameter int CLK_NS     = 5,
   parameter int BURST_LEN  = 4,
   parameter int T_REFI_NS  = 7600,
   parameter int T_RFC_NS   = 120,
   parameter int T_HOP_NS   = 55,
   parameter int T_RCD_NS   = 15,
   parameter int T_CAS_NS   = 10,
   parameter int T_DQSS_NS  = 10,
   parameter int T_WTR_NS   = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   output logic             cmd_ready,
   input  logic             cmd_write,
   input  logic [BANK_W-1:0] cmd_bank,
   input  logic [ROW_W-1:0]  cmd_row,
   input  logic [COL_W-1:0]  cmd_col,
   output logic             wr_strobe,
   output logic             rd_valid
);
   localparam int XFER_PER_CLK = 2;
   localparam int BURST_C = BURST_LEN / XFER_PER_CLK;
   localparam int ALIGN_W = $clog2(BURST_LEN);
   localparam int REFI_C  = ns_to_cyc(T_REFI_NS, CLK_NS);
   localparam int RFC_C   = ns_to_cyc(T_RFC_NS, CLK_NS);
   localparam int HOP_C   = ns_to_cyc(T_HOP_NS, CLK_NS);
   localparam int RCD_C   = ns_to_cyc(T_RCD_NS, CLK_NS);
   localparam int CAS_C   = ns_to_cyc(T_CAS_NS, CLK_NS);
   localparam int DQSS_C  = ns_to_cyc(T_DQSS_NS, CLK_NS);
   localparam int WTR_C   = ns_to_cyc(T_WTR_NS, CLK_NS);

   if (BANK_W + ROW_W + COL_W != ADDR_W) begin : g_bad_addr
      $error("dram_timing_engine: bank, row and column widths must sum to ADDR_W");
   end
   if (BURST_LEN < XFER_PER_CLK || BURST_LEN % XFER_PER_CLK != 0) begin : g_bad_burst
      $error("dram_timing_engine: BURST_LEN must be a positive multiple of 2");
   end
   if (ALIGN_W >= COL_W) begin : g_bad_align
      $error("dram_timing_engine: burst wider than the column field");
   end

   logic row_hit, bank_open, ref_pend, ref_ack, accept;

   dte_refresh #(.INTERVAL(REFI_C)) u_ref (
      .clk     (clk),
      .rst_n   (rst_n),
      .ack     (ref_ack),
      .pending (ref_pend)
   );

   dte_bank_table #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_banks (
      .clk       (clk),
      .rst_n     (rst_n),
      .q_bank    (cmd_bank),
      .q_row     (cmd_row),
      .hit       (row_hit),
      .is_open   (bank_open),
      .upd       (accept),
      .close_all (ref_ack)
   );

   dte_sched #(
      .HOP_C(HOP_C), .RCD_C(RCD_C), .CAS_C(CAS_C), .DQSS_C(DQSS_C),
      .WTR_C(WTR_C), .REF_C(RFC_C), .BURST_C(BURST_C)
   ) u_sched (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_write (cmd_write),
      .row_hit   (row_hit),
      .bank_open (bank_open),
      .ref_pend  (ref_pend),
      .cmd_ready (cmd_ready),
      .accept    (accept),
      .ref_ack   (ref_ack),
      .rd_valid  (rd_valid),
      .wr_strobe (wr_strobe)
   );

   // R2
   col_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> cmd_col[ALIGN_W-1:0] == '0);
   // R9
   ref_only_when_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cmd_ready) |-> $past(accept) || ref_pend);
endmodule

// File: tb/sim_dram_timing_engine.sv
`timescale 1ns/1ps
module sim_dram_timing_engine;
   localparam int REFI = 1520, RFC = 24, HOP = 11, RCD = 3;
   localparam int CAS = 2, DQSS = 2, WTR = 2, BURST = 2;
   localparam int RUN_CYCLES = 7000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_valid = 1'b0, cmd_write = 1'b0;
   logic [1:0]  cmd_bank = '0;
   logic [12:0] cmd_row = '0;
   logic [9:0]  cmd_col = '0;
   logic cmd_ready, wr_strobe, rd_valid;

   int checks = 0, fails = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   dram_timing_engine u0 (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_write(cmd_write), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
      .cmd_col(cmd_col), .wr_strobe(wr_strobe), .rd_valid(rd_valid)
   );

   // reference state, built from the requirements
   int m_mode = 0;   // 0 idle, 1 waiting for data, 2 data beats, 3 blackout
   int m_cnt = 0, m_rc = 0;
   bit m_pend = 0, m_wr = 0, m_last_wr = 0, m_defer = 0;
   bit m_vld [4];
   int m_row [4];
   string m_tag = "R1";

   function automatic int lead_cycles(input bit wr, input int bank, input int row,
                                      output string tag);
      int d = wr ? DQSS : CAS;
      tag = wr ? "R3" : "R2";
      if (!m_vld[bank]) begin d += RCD; tag = "R4"; end
      else if (m_row[bank] != row) begin d += HOP + RCD; tag = "R5"; end
      if (!wr && m_last_wr) begin d += WTR; tag = "R6"; end
      return d;
   endfunction

   task automatic check(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic step_model(input bit v, input bit wr, input int bank, input int row);
      bit rdy = (m_mode == 0) && !m_pend;
      bit acc = v && rdy;
      bit ack = (m_mode == 0) && m_pend;
      bit due = (m_rc == REFI - 1);
      string t;
      int d;
      m_rc = due ? 0 : m_rc + 1;
      case (m_mode)
         0: if (ack) begin
               m_mode = 3; m_cnt = RFC;
               m_tag = m_defer ? "R10" : "R9";
               foreach (m_vld[i]) m_vld[i] = 0;
            end else if (acc) begin
               d = lead_cycles(wr, bank, row, t);
               if (t == "R4" && m_tag inside {"R9", "R10", "R11"}) t = "R11";
               m_tag = t;
               m_mode = 1; m_cnt = d; m_wr = wr; m_last_wr = wr;
               m_vld[bank] = 1; m_row[bank] = row;
            end
         1: if (m_cnt == 1) begin m_mode = 2; m_cnt = BURST; end else m_cnt--;
         default: if (m_cnt == 1) m_mode = 0; else m_cnt--;
      endcase
      if (due) begin m_pend = 1; m_defer = !(m_mode == 0 || ack); end
      else if (ack) m_pend = 0;
   endtask

   task automatic compare_outputs();
      bit e_rdy = (m_mode == 0) && !m_pend;
      bit e_rd  = (m_mode == 2) && !m_wr;
      bit e_wr  = (m_mode == 2) && m_wr;
      string rt = (m_mode == 3 || m_pend) ? m_tag : "R8";
      string st = (m_mode == 2) ? "R7" : m_tag;
      if (e_rd || e_wr) st = m_tag;
      check(rt, "cmd_ready", int'(cmd_ready), int'(e_rdy));
      check(st, "rd_valid",  int'(rd_valid),  int'(e_rd));
      check(st, "wr_strobe", int'(wr_strobe), int'(e_wr));
      check("R7", "strobe overlap", int'(rd_valid && wr_strobe), 0);
   endtask

   // directed opening: closed bank, hit read, hit write, read after write,
   // row hop, hop on another bank
   bit dir_wr  [6] = '{0, 0, 1, 0, 0, 1};
   int dir_bk  [6] = '{0, 0, 0, 0, 0, 2};
   int dir_row [6] = '{5, 5, 5, 5, 6, 9};

   initial begin
      int unsigned seed_v;
      int di = 0;
      bit hold = 0;
      seed_v = $urandom(32'd20240611);
      foreach (m_vld[i]) begin m_vld[i] = 0; m_row[i] = 0; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      check("R1", "cmd_ready after reset", int'(cmd_ready), 1);
      check("R1", "rd_valid after reset",  int'(rd_valid), 0);
      check("R1", "wr_strobe after reset", int'(wr_strobe), 0);
      for (int cyc = 0; cyc < RUN_CYCLES; cyc++) begin
         compare_outputs();
         if (!hold) begin
            if (di < 6) begin
               cmd_valid = 1'b1; cmd_write = dir_wr[di];
               cmd_bank = 2'(dir_bk[di]); cmd_row = 13'(dir_row[di]);
               cmd_col = 10'($urandom_range(0, 255) * 4);
            end else begin
               cmd_valid = ($urandom_range(0, 9) < 7);
               cmd_write = $urandom_range(0, 1);
               cmd_bank  = 2'($urandom_range(0, 3));
               cmd_row   = 13'($urandom_range(0, 2));
               cmd_col   = 10'($urandom_range(0, 255) * 4);
            end
         end
         hold = cmd_valid && !((m_mode == 0) && !m_pend);
         if (cmd_valid && !hold && di < 6) di++;
         step_model(cmd_valid, cmd_write, int'(cmd_bank), int'(cmd_row));
         @(negedge clk);
      end
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(4 * (RUN_CYCLES + 2000));
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule